// File: doc/BRIEF.md
# Dual Down-Counter Timer Block with Interrupt Registers

This block is a byte-wide peripheral holding sixteen registers. Two 16-bit timers count down on a shared tick. The tick comes from an internal prescaler that divides the block clock by six; the intended clock is a 4.7 MHz reference. A flag register records timer events and an enable register selects which flags drive the active-high interrupt line. The first timer runs periodically and reloads from its latch after passing through 0xFFFF. The second timer is a one-shot that reports a single event for each load.

A host reaches the block through a simple strobe interface. `sel_i` together with `wr_i` performs a write at the clock edge. `sel_i` with `wr_i` low performs a read. The read data is always shown combinationally for the register that `addr_i` selects. Read side effects are applied at the edge only when `sel_i` is high.

Top module: `dual_timer_regs`

## Requirements
- R1: After reset, both latches read 0xFFFF, the first timer counter holds 0xFFFF, the direction-B register (index 2) reads 0xFF, the enable register reads 0x80, and every other register reads 0.
- R2: The register index is taken from `addr_i[12:9]`, and `addr_i[8:0]` is ignored. The general registers at indexes 0, 1, 2, 3, 10, 11, 12 and 15 read back the last byte written to them. Indexes 1 and 15 are separate registers.
- R3: The enable register is at index 14 and always reads with bit 7 set. A write with bit 7 = 1 ORs bits 6:0 into the enables. A write with bit 7 = 0 clears every enable bit written as 1.
- R4: The flag register is at index 13. It reads as the flags, with bit 7 set whenever any flag is pending whose enable is also set. Writing it clears each flag bit written as 1.
- R5: `irq_o` is high exactly when (flags AND enables AND 0x64) is nonzero.
- R6: Writing index 4 or 6 sets the low byte of the first latch. Writing index 7 sets its high byte and clears flag bit 6, without reloading the counter. Writing index 5 sets the high byte, clears flag bit 6, and loads the counter with the new latch value. Indexes 6 and 7 read back the latch bytes.
- R7: A tick occurs on every sixth clock after reset. On each tick the first counter decrements. After it passes 0 it holds 0xFFFF for one tick, and on the next tick it reloads from the latch, so one period lasts latch+2 ticks.
- R8: Flag bit 6 is set on the tick on which the first counter becomes 0, but only while bits 7:6 of the auxiliary control register (index 11) equal 01.
- R9: Reading index 4 clears flag bit 6, and reading index 8 clears flag bit 5. Indexes 4 and 5 return the low and high bytes of the first counter, and indexes 8 and 9 return those of the second counter.
- R10: Writing index 8 sets the low byte of the second latch. Writing index 9 sets its high byte, clears flag bit 5, and loads the second counter from the latch. Flag bit 5 is set the first time that counter reaches 0 after a load, and not again until the next load. The counter keeps decrementing and wraps.
- R11: When a timer event and a flag clear fall in the same cycle, the flag ends set. A counter load written in a cycle that also carries a tick takes the written value, and that cycle produces no event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock (prescaler reference) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Access strobe, one access per cycle |
| wr_i | input | 1 | 1 = write, 0 = read (with sel_i) |
| addr_i | input | 13 | Byte address; index in bits 12:9 |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the addressed register |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
A timer event can land in the same clock as a host access that clears the same flag, whether that access is a counter-low read, a latch-high write or a flag-register write. A reload write can also land in the same clock as a prescaler tick. The bench provokes these collisions by holding each such access for many back-to-back cycles while a short-latch timer runs, so that the access covers every phase of the tick. A cycle-level reference model judges each cycle: it counts the tick phase itself and applies set-over-clear and load-over-count, and the counter bytes, the flag register and the interrupt line are compared with it on every clock.

// File: rtl/dtr_pkg.sv
package dtr_pkg;

  typedef enum logic [3:0] {
    RI_PORTB      = 4'd0,
    RI_PORTA      = 4'd1,
    RI_DIRB       = 4'd2,
    RI_DIRA       = 4'd3,
    RI_T1_CNT_LO  = 4'd4,
    RI_T1_CNT_HI  = 4'd5,
    RI_T1_LAT_LO  = 4'd6,
    RI_T1_LAT_HI  = 4'd7,
    RI_T2_LO      = 4'd8,
    RI_T2_HI      = 4'd9,
    RI_SHIFT      = 4'd10,
    RI_AUXCTL     = 4'd11,
    RI_PERCTL     = 4'd12,
    RI_FLAGS      = 4'd13,
    RI_ENABLES    = 4'd14,
    RI_PORTA_RAW  = 4'd15
  } reg_idx_e;

  localparam int unsigned FLAG_W   = 7;
  localparam int unsigned FLAG_T1  = 6;
  localparam int unsigned FLAG_T2  = 5;
  localparam logic [FLAG_W-1:0] IRQ_SRC_MASK = 7'h64;

  // general-purpose byte registers: 0..3, 10..12, 15
  localparam logic [15:0] PLAIN_MASK = 16'b1001_1100_0000_1111;
  localparam logic [7:0]  DIRB_RST   = 8'hFF;

endpackage

// File: rtl/dtr_prescaler.sv
module dtr_prescaler #(
  parameter int unsigned DIV = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  generate
    if (DIV > 1) begin : g_gap_chk
      p_tick_gap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate

endmodule

// File: rtl/dtr_timer.sv
module dtr_timer #(
  parameter int unsigned DATA_W          = 8,
  parameter bit          RELOAD_THRU_NEG = 1'b1,
  parameter int unsigned CNT_RST         = 'hFFFF
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                gate_i,
  input  logic                lo_we_i,
  input  logic                hi_we_i,
  input  logic                load_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [2*DATA_W-1:0] cnt_o,
  output logic [2*DATA_W-1:0] lat_o,
  output logic                hit_o
);
  localparam int unsigned CNT_W = 2 * DATA_W;

  logic [CNT_W-1:0] cnt_q, cnt_d, lat_q, load_val;

  assign load_val = {wdata_i, lat_q[DATA_W-1:0]};
  assign cnt_o    = cnt_q;
  assign lat_o    = lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= '1;
    end else begin
      if (lo_we_i) lat_q[DATA_W-1:0]     <= wdata_i;
      if (hi_we_i) lat_q[CNT_W-1:DATA_W] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= CNT_W'(CNT_RST);
    else         cnt_q <= cnt_d;
  end

  generate
    if (RELOAD_THRU_NEG) begin : g_periodic
      logic wrap_q, wrap_d;

      always_comb begin
        cnt_d  = cnt_q;
        wrap_d = wrap_q;
        if (load_i) begin
          cnt_d  = load_val;
          wrap_d = 1'b0;
        end else if (tick_i) begin
          if (wrap_q) begin
            cnt_d  = lat_q;
            wrap_d = 1'b0;
          end else if (cnt_q == '0) begin
            cnt_d  = '1;
            wrap_d = 1'b1;
          end else begin
            cnt_d  = cnt_q - 1'b1;
          end
        end
      end

      assign hit_o = !load_i && tick_i && (cnt_d == '0) && gate_i;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) wrap_q <= 1'b0;
        else         wrap_q <= wrap_d;
      end

      p_reload_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wrap_q && tick_i && !load_i) |=> (cnt_q == $past(lat_q)));
      p_minus_one_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wrap_q && tick_i && !load_i && cnt_q == '0) |=> (cnt_q == '1));
    end else begin : g_oneshot
      logic arm_q;

      always_comb begin
        cnt_d = cnt_q;
        if (load_i)      cnt_d = load_val;
        else if (tick_i) cnt_d = cnt_q - 1'b1;
      end

      assign hit_o = !load_i && tick_i && (cnt_d == '0) && gate_i && arm_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     arm_q <= 1'b0;
        else if (load_i) arm_q <= 1'b1;
        else if (hit_o)  arm_q <= 1'b0;
      end

      p_once_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit_o |=> !arm_q);
    end
  endgenerate

  p_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == {$past(wdata_i), $past(lat_q[DATA_W-1:0])}));

endmodule

// File: rtl/dtr_irq.sv
module dtr_irq
  import dtr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FLAG_W-1:0] set_i,
  input  logic [FLAG_W-1:0] clr_i,
  input  logic              ier_we_i,
  input  logic [7:0]        wdata_i,
  output logic [FLAG_W-1:0] ifr_o,
  output logic [FLAG_W-1:0] ier_o,
  output logic              pend_o,
  output logic              irq_o
);
  logic [FLAG_W-1:0] ifr_q, ier_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ifr_q <= '0;
    else         ifr_q <= (ifr_q & ~clr_i) | set_i;  // set beats clear
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ier_q <= '0;
    else if (ier_we_i) ier_q <= wdata_i[7] ? (ier_q | wdata_i[FLAG_W-1:0])
                                           : (ier_q & ~wdata_i[FLAG_W-1:0]);
  end

  assign ifr_o  = ifr_q;
  assign ier_o  = ier_q;
  assign pend_o = |(ifr_q & ier_q);
  assign irq_o  = |(ifr_q & ier_q & IRQ_SRC_MASK);

  p_set_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((ifr_q & $past(set_i)) == $past(set_i)));
  p_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_i & ~set_i)) |=> ((ifr_q & $past(clr_i & ~set_i)) == '0));
  p_ier_or_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ier_we_i && wdata_i[7]) |=>
      ((ier_q & $past(wdata_i[FLAG_W-1:0])) == $past(wdata_i[FLAG_W-1:0])));
  p_ier_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ier_we_i && !wdata_i[7]) |=> ((ier_q & $past(wdata_i[FLAG_W-1:0])) == '0));

endmodule

// File: rtl/dual_timer_regs.sv
module dual_timer_regs
  import dtr_pkg::*;
#(
  parameter int unsigned ADDR_W       = 13,
  parameter int unsigned IDX_LSB      = 9,
  parameter int unsigned PRESCALE_DIV = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              irq_o
);
  localparam int unsigned DATA_W = 8;
  localparam int unsigned CNT_W  = 2 * DATA_W;
  localparam int unsigned NREG   = 16;

  reg_idx_e idx;
  logic     wr, rd, tick, addr_unused;
  logic     hit1, hit2, t1_cont, pend;
  logic [CNT_W-1:0]  cnt1, lat1, cnt2, lat2;
  logic [FLAG_W-1:0] set_v, clr_v, ifr, ier;
  logic [DATA_W-1:0] plain_rd [NREG];

  assign idx         = reg_idx_e'(addr_i[IDX_LSB +: 4]);
  assign addr_unused = ^addr_i[IDX_LSB-1:0];
  assign wr          = sel_i && wr_i;
  assign rd          = sel_i && !wr_i;

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_plain
      if (PLAIN_MASK[i]) begin : g_reg
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni)                        q <= (i == int'(RI_DIRB)) ? DIRB_RST : '0;
          else if (wr && idx == reg_idx_e'(i)) q <= wdata_i;
        end
        assign plain_rd[i] = q;
      end else begin : g_none
        assign plain_rd[i] = '0;
      end
    end
  endgenerate

  assign t1_cont = (plain_rd[RI_AUXCTL][7:6] == 2'b01);

  dtr_prescaler #(.DIV(PRESCALE_DIV)) u_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  dtr_timer #(.DATA_W(DATA_W), .RELOAD_THRU_NEG(1'b1), .CNT_RST('hFFFF)) u_tmr1 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .gate_i (t1_cont),
    .lo_we_i(wr && (idx == RI_T1_CNT_LO || idx == RI_T1_LAT_LO)),
    .hi_we_i(wr && (idx == RI_T1_CNT_HI || idx == RI_T1_LAT_HI)),
    .load_i (wr && idx == RI_T1_CNT_HI),
    .wdata_i(wdata_i),
    .cnt_o  (cnt1),
    .lat_o  (lat1),
    .hit_o  (hit1)
  );

  dtr_timer #(.DATA_W(DATA_W), .RELOAD_THRU_NEG(1'b0), .CNT_RST(0)) u_tmr2 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .gate_i (1'b1),
    .lo_we_i(wr && idx == RI_T2_LO),
    .hi_we_i(wr && idx == RI_T2_HI),
    .load_i (wr && idx == RI_T2_HI),
    .wdata_i(wdata_i),
    .cnt_o  (cnt2),
    .lat_o  (lat2),
    .hit_o  (hit2)
  );

  always_comb begin
    set_v          = '0;
    set_v[FLAG_T1] = hit1;
    set_v[FLAG_T2] = hit2;
    clr_v          = '0;
    if (wr && idx == RI_FLAGS) clr_v = wdata_i[FLAG_W-1:0];
    if ((wr && (idx == RI_T1_CNT_HI || idx == RI_T1_LAT_HI)) ||
        (rd && idx == RI_T1_CNT_LO))
      clr_v[FLAG_T1] = 1'b1;
    if ((wr && idx == RI_T2_HI) || (rd && idx == RI_T2_LO))
      clr_v[FLAG_T2] = 1'b1;
  end

  dtr_irq u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (set_v),
    .clr_i   (clr_v),
    .ier_we_i(wr && idx == RI_ENABLES),
    .wdata_i (wdata_i),
    .ifr_o   (ifr),
    .ier_o   (ier),
    .pend_o  (pend),
    .irq_o   (irq_o)
  );

  always_comb begin
    unique case (idx)
      RI_T1_CNT_LO: rdata_o = cnt1[DATA_W-1:0];
      RI_T1_CNT_HI: rdata_o = cnt1[CNT_W-1:DATA_W];
      RI_T1_LAT_LO: rdata_o = lat1[DATA_W-1:0];
      RI_T1_LAT_HI: rdata_o = lat1[CNT_W-1:DATA_W];
      RI_T2_LO:     rdata_o = cnt2[DATA_W-1:0];
      RI_T2_HI:     rdata_o = cnt2[CNT_W-1:DATA_W];
      RI_FLAGS:     rdata_o = {pend, ifr};
      RI_ENABLES:   rdata_o = {1'b1, ier};
      default:      rdata_o = plain_rd[idx];
    endcase
  end

  // second latch high byte is write-only; keep its use explicit
  logic lat2_unused;
  assign lat2_unused = ^lat2[CNT_W-1:DATA_W] ^ addr_unused;

  p_flag_clr_on_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && idx == RI_T1_CNT_HI) |=> !ifr[FLAG_T1]);
  p_t1_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!t1_cont && !ifr[FLAG_T1]) |=> !ifr[FLAG_T1]);
  p_irq_src_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> pend);

endmodule

// File: tb/dual_timer_regs_tb_top.sv
module dual_timer_regs_tb_top;
  localparam int CLK_P    = 10;
  localparam int WDOG_CYC = 20000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sel_i = 1'b0;
  logic        wr_i = 1'b0;
  logic [12:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic        irq_o;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    fin = 1'b0;
  string cur_req = "R1";

  dual_timer_regs dut_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (sel_i),
    .wr_i   (wr_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .rdata_o(rdata_o),
    .irq_o  (irq_o)
  );

  always #(CLK_P/2) clk_i = ~clk_i;

  // reference model
  int         m_presc;
  logic [15:0] m_c1, m_l1, m_c2, m_l2;
  bit          m_wrap, m_arm;
  logic [6:0]  m_ifr, m_ier;
  logic [7:0]  m_gen [16];

  function automatic bit is_gen(int ix);
    return (ix <= 3) || (ix >= 10 && ix <= 12) || (ix == 15);
  endfunction

  function automatic logic [7:0] exp_rd(int ix);
    case (ix)
      4:  return m_c1[7:0];
      5:  return m_c1[15:8];
      6:  return m_l1[7:0];
      7:  return m_l1[15:8];
      8:  return m_c2[7:0];
      9:  return m_c2[15:8];
      13: return {|(m_ifr & m_ier), m_ifr};
      14: return {1'b1, m_ier};
      default: return m_gen[ix];
    endcase
  endfunction

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_presc = 0; m_c1 = 16'hFFFF; m_l1 = 16'hFFFF; m_c2 = 0; m_l2 = 16'hFFFF;
      m_wrap = 0; m_arm = 0; m_ifr = 0; m_ier = 0;
      for (int i = 0; i < 16; i++) m_gen[i] = (i == 2) ? 8'hFF : 8'h00;
    end else begin
      bit tk, w, r, h1, h2;
      int ix;
      logic [6:0] clr;
      tk = (m_presc == 5);
      m_presc = tk ? 0 : m_presc + 1;
      w = sel_i && wr_i;
      r = sel_i && !wr_i;
      ix = int'(addr_i[12:9]);
      h1 = 0; h2 = 0;
      if (w && ix == 5) begin
        m_c1 = {wdata_i, m_l1[7:0]}; m_wrap = 0;
      end else if (tk) begin
        if (m_wrap) begin m_c1 = m_l1; m_wrap = 0; end
        else if (m_c1 == 0) begin m_c1 = 16'hFFFF; m_wrap = 1; end
        else m_c1 = m_c1 - 1;
        h1 = (m_c1 == 0) && (m_gen[11][7:6] == 2'b01);
      end
      if (w && ix == 9) begin
        m_c2 = {wdata_i, m_l2[7:0]}; m_arm = 1;
      end else if (tk) begin
        m_c2 = m_c2 - 1;
        if (m_arm && m_c2 == 0) begin h2 = 1; m_arm = 0; end
      end
      clr = 0;
      if (w && ix == 13) clr = wdata_i[6:0];
      if ((w && (ix == 5 || ix == 7)) || (r && ix == 4)) clr[6] = 1;
      if ((w && ix == 9) || (r && ix == 8)) clr[5] = 1;
      m_ifr = (m_ifr & ~clr) | {h1, h2, 5'b0};
      if (w && ix == 14) m_ier = wdata_i[7] ? (m_ier | wdata_i[6:0]) : (m_ier & ~wdata_i[6:0]);
      if (w && (ix == 4 || ix == 6)) m_l1[7:0] = wdata_i;
      if (w && (ix == 5 || ix == 7)) m_l1[15:8] = wdata_i;
      if (w && ix == 8) m_l2[7:0] = wdata_i;
      if (w && ix == 9) m_l2[15:8] = wdata_i;
      if (w && is_gen(ix)) m_gen[ix] = wdata_i;
    end
  end

  task automatic check8(string tag, string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%02h expected=%02h @%0t", tag, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always begin
    @(negedge clk_i);
    #(CLK_P/4);
    if (rst_ni && !fin) begin
      check8(cur_req, $sformatf("rdata idx%0d", addr_i[12:9]), rdata_o, exp_rd(int'(addr_i[12:9])));
      check8("R5", "irq_o", {7'b0, irq_o}, {7'b0, |(m_ifr & m_ier & 7'h64)});
    end
  end

  task automatic drive(bit w, int ix, logic [7:0] d, int n);
    @(negedge clk_i);
    sel_i = 1'b1; wr_i = w; addr_i = {ix[3:0], 9'h0A5}; wdata_i = d;
    repeat (n) @(negedge clk_i);
    sel_i = 1'b0;
  endtask

  task automatic wr(int ix, logic [7:0] d);
    drive(1'b1, ix, d, 1);
  endtask

  task automatic idle(int ix, int n);
    @(negedge clk_i);
    sel_i = 1'b0; addr_i = {ix[3:0], 9'h15A};
    repeat (n) @(negedge clk_i);
  endtask

  task automatic expect_rd(string tag, int ix, logic [7:0] exp);
    @(negedge clk_i);
    sel_i = 1'b0; addr_i = {ix[3:0], 9'h1FF};
    #(CLK_P/4);
    check8(tag, $sformatf("explicit idx%0d", ix), rdata_o, exp);
  endtask

  task automatic expect_irq(string tag, bit exp);
    #(CLK_P/4);
    check8(tag, "explicit irq_o", {7'b0, irq_o}, {7'b0, exp});
  endtask

  task automatic finish_run();
    fin = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (WDOG_CYC) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1: reset values
    cur_req = "R1";
    expect_rd("R1", 2, 8'hFF);
    expect_rd("R1", 14, 8'h80);
    expect_rd("R1", 6, 8'hFF);
    expect_rd("R1", 7, 8'hFF);
    expect_rd("R1", 13, 8'h00);
    expect_rd("R1", 11, 8'h00);
    expect_rd("R1", 15, 8'h00);

    // R2: general registers, low address bits ignored
    cur_req = "R2";
    wr(0, 8'h11); wr(1, 8'h22); wr(3, 8'h33); wr(10, 8'h44); wr(12, 8'h55); wr(15, 8'h66);
    expect_rd("R2", 0, 8'h11);
    expect_rd("R2", 1, 8'h22);
    expect_rd("R2", 15, 8'h66);
    expect_rd("R2", 12, 8'h55);

    // R3: enable set/clear semantics
    cur_req = "R3";
    wr(14, 8'hE0);
    expect_rd("R3", 14, 8'hE0);
    wr(14, 8'h20);
    expect_rd("R3", 14, 8'hC0);
    wr(14, 8'hA4);
    expect_rd("R3", 14, 8'hE4);

    // R6 R7 R8: periodic timer, continuous mode
    cur_req = "R6";
    wr(11, 8'h40);
    wr(6, 8'h04);
    wr(7, 8'h00);
    expect_rd("R6", 6, 8'h04);
    expect_rd("R6", 7, 8'h00);
    wr(5, 8'h00);
    cur_req = "R7";
    idle(4, 60);
    cur_req = "R8";
    expect_rd("R8", 13, 8'hC0);
    expect_irq("R5", 1'b1);

    // R8: gate closed, no new flag
    wr(11, 8'h00);
    wr(13, 8'h7F);
    idle(5, 80);
    expect_rd("R8", 13, 8'h00);
    expect_irq("R8", 1'b0);

    // R10 R9: one-shot timer
    cur_req = "R10";
    wr(8, 8'h03);
    wr(9, 8'h00);
    idle(8, 30);
    expect_rd("R10", 13, 8'hA0);
    cur_req = "R9";
    drive(1'b0, 8, 8'h00, 1);
    idle(9, 60);
    expect_rd("R10", 13, 8'h00);
    idle(8, 20);

    // R11: collisions of timer events with clears and loads
    cur_req = "R11";
    wr(11, 8'h40);
    wr(6, 8'h01);
    wr(5, 8'h00);
    drive(1'b0, 4, 8'h00, 100);
    drive(1'b1, 7, 8'h00, 60);
    drive(1'b1, 13, 8'h40, 60);
    drive(1'b1, 5, 8'h00, 40);
    idle(4, 30);

    // R4 R5: pending bit and interrupt masking
    cur_req = "R4";
    wr(11, 8'h00);
    wr(13, 8'h7F);
    wr(14, 8'h7F);
    wr(8, 8'h02);
    wr(9, 8'h00);
    idle(13, 30);
    expect_rd("R4", 13, 8'h20);
    expect_irq("R5", 1'b0);
    wr(14, 8'h84);
    expect_rd("R4", 13, 8'h20);
    expect_irq("R5", 1'b0);
    wr(14, 8'hA0);
    expect_rd("R4", 13, 8'hA0);
    expect_irq("R5", 1'b1);
    wr(13, 8'h20);
    expect_rd("R4", 13, 8'h00);
    expect_irq("R5", 1'b0);

    idle(0, 4);
    finish_run();
  end

endmodule